// File: doc/BRIEF.md
# Multiplexed Cartridge Address Latch-Counter

This block sits between a game cartridge bus and a 16-bit parallel flash. On the cartridge bus the low sixteen address bits share their pins with the data bus, and only the upper eight address bits have dedicated pins. When the cartridge select falls, the block captures the low address from the shared pins into a loadable up counter. At the same edge it captures the upper bits into a separate holding register.

Each completed read or write strobe inside the select window advances the counter by one flash word. Back-to-back sequential accesses therefore need no fresh address phase. The counter drives the flash word address directly, with bit 0 of the counter on flash address bit 0, so the flash runs in 16-bit word mode. The flash sees an address that stays stable, not latched, for every strobe. The chip enable follows the cartridge select and is not toggled between words of a burst.

The block also derives the flash output and write enables. It drives the shared pins toward the bus only during a selected read. All bus inputs are sampled on the system clock; edges are detected between consecutive samples.

Top module: `cart_addr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the counter and the upper holding register clear, so `flashAddr` reads 0x000000 after reset.
- R2: In the first clock after `csN` is sampled going from 1 to 0, `flashAddr[15:0]` takes the value of `adIn` and `flashAddr[23:16]` takes the value of `hiAddr`, both as sampled at that edge.
- R3: A rising edge of `rdN` sampled while `csN` is low advances `flashAddr[15:0]` by exactly one in the following clock.
- R4: A rising edge of `wrN` sampled while `csN` is low advances `flashAddr[15:0]` by exactly one in the following clock.
- R5: The counter wraps from 0xFFFF to 0x0000, and a carry out of the counter never changes `flashAddr[23:16]`.
- R6: Read or write strobes while `csN` is high leave `flashAddr` unchanged.
- R7: While `csN` and `rdN` both stay low, `flashAddr` holds its value. `flashCeN` equals `csN` and stays low for the whole burst.
- R8: `adOe` is 1 exactly when `csN` and `rdN` are both low. At that time `adOut` equals `flashData`; otherwise `adOut` is 0.
- R9: `flashOeN` is low only when `csN` and `rdN` are both low, and `flashWeN` is low only when `csN` and `wrN` are both low.
- R10: Changes on `hiAddr` or `adIn` after the select edge, while `csN` stays low, do not alter `flashAddr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Cartridge select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| adIn | input | 16 | Shared pins as seen by the block (low address) |
| hiAddr | input | 8 | Dedicated upper address pins |
| adOut | output | 16 | Data driven toward the shared pins |
| adOe | output | 1 | Drive enable for the shared pins |
| flashData | input | 16 | Read data from the flash |
| flashAddr | output | 24 | Flash word address (upper held bits and counter) |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashOeN | output | 1 | Flash output enable, active low |
| flashWeN | output | 1 | Flash write enable, active low |

## Verification
Bursts start from a sweep of start addresses that includes zero, mid-range values, values just below the top and 0xFFFF itself. Bursts of every length up to twenty words use read-only, write-only and alternating strobe mixes, and the expected address is the start plus the strobe count modulo 65536. The near-top starts separate a correct wrap from a carry leaking into the upper byte. Read-only and write-only runs show that each strobe type steps the counter by itself. Strobes issued with the select high, and address pins changed in the middle of a burst, show that only the select edge loads the address. During each read strobe the bench checks the output enable, the data passthrough and the held address.

// File: rtl/cart_pkg.sv
package cart_pkg;
  localparam int LO_W = 16;
  localparam int HI_W = 8;

  typedef struct packed {
    logic load;
    logic step;
  } ctlStrobe_t;
endpackage

// File: rtl/cart_ctl.sv
module cart_ctl
  import cart_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  output ctlStrobe_t strobe
);
  logic csPrev, rdPrev, wrPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      csPrev <= 1'b1;
      rdPrev <= 1'b1;
      wrPrev <= 1'b1;
    end else begin
      csPrev <= csN;
      rdPrev <= rdN;
      wrPrev <= wrN;
    end
  end

  always_comb begin
    strobe.load = csPrev & ~csN & ~rst;
    strobe.step = ~csN & ~rst & ~strobe.load &
                  ((rdN & ~rdPrev) | (wrN & ~wrPrev));
  end

  // R2 R3
  load_step_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.load, strobe.step}));

  // R6
  step_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.step |-> (!csN && !csPrev));
endmodule

// File: rtl/cart_dp.sv
module cart_dp
  import cart_pkg::*;
#(
  parameter int LoW = LO_W,
  parameter int HiW = HI_W
) (
  input  logic           clk,
  input  logic           rst,
  input  ctlStrobe_t     strobe,
  input  logic [LoW-1:0] loadLo,
  input  logic [HiW-1:0] loadHi,
  output logic [LoW-1:0] cntLo,
  output logic [HiW-1:0] holdHi
);
  localparam logic [LoW-1:0] ONE = LoW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cntLo  <= '0;
      holdHi <= '0;
    end else if (strobe.load) begin
      cntLo  <= loadLo;
      holdHi <= loadHi;
    end else if (strobe.step) begin
      cntLo  <= cntLo + ONE;
    end
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (cntLo == $past(loadLo) && holdHi == $past(loadHi)));

  // R3
  step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.step |=> (cntLo == $past(cntLo) + ONE));

  // R5
  hi_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(holdHi));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.load && !strobe.step) |=> $stable(cntLo));
endmodule

// File: rtl/cart_addr_seq.sv
module cart_addr_seq
  import cart_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 csN,
  input  logic                 rdN,
  input  logic                 wrN,
  input  logic [LO_W-1:0]      adIn,
  input  logic [HI_W-1:0]      hiAddr,
  output logic [LO_W-1:0]      adOut,
  output logic                 adOe,
  input  logic [LO_W-1:0]      flashData,
  output logic [LO_W+HI_W-1:0] flashAddr,
  output logic                 flashCeN,
  output logic                 flashOeN,
  output logic                 flashWeN
);
  ctlStrobe_t      strobe;
  logic [LO_W-1:0] cntLo;
  logic [HI_W-1:0] holdHi;

  cart_ctl u_ctl (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN), .strobe(strobe)
  );

  cart_dp #(.LoW(LO_W), .HiW(HI_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .loadLo(adIn), .loadHi(hiAddr), .cntLo(cntLo), .holdHi(holdHi)
  );

  always_comb begin
    flashAddr = {holdHi, cntLo};
    flashCeN  = csN;
    flashOeN  = csN | rdN;
    flashWeN  = csN | wrN;
    adOe      = ~(csN | rdN);
    adOut     = adOe ? flashData : '0;
  end

  // R7
  read_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!csN && !rdN && $past(!csN && !rdN)) |-> $stable(flashAddr));

  // R8
  drive_only_read_chk: assert property (@(posedge clk) disable iff (rst)
    adOe |-> (!flashOeN && !flashCeN));
endmodule

// File: tb/cart_addr_seq_test.sv
module cart_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [15:0] adIn = '0, flashData = '0, adOut;
  logic [7:0]  hiAddr = '0;
  logic        adOe, flashCeN, flashOeN, flashWeN;
  logic [23:0] flashAddr;
  int vectors = 0, miscompares = 0;

  always #4 clk = ~clk;

  cart_addr_seq uut (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN), .adIn(adIn),
    .hiAddr(hiAddr), .adOut(adOut), .adOe(adOe), .flashData(flashData),
    .flashAddr(flashAddr), .flashCeN(flashCeN), .flashOeN(flashOeN),
    .flashWeN(flashWeN)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic startBurst(logic [15:0] lo, logic [7:0] hi);
    adIn = lo; hiAddr = hi; csN = 1'b0;
    tick();
    check("R2", flashAddr, {hi, lo});
    check("R7", flashCeN, 1'b0);
  endtask

  task automatic readStrobe(logic [23:0] cur, logic [15:0] dat);
    flashData = dat; rdN = 1'b0;
    adIn = ~cur[15:0]; hiAddr = ~cur[23:16];
    tick();
    check("R8", {adOe, adOut}, {1'b1, dat});
    check("R9", {flashOeN, flashWeN}, 2'b01);
    tick();
    check("R7", flashAddr, cur);
    rdN = 1'b1;
    tick();
    check("R8", {adOe, adOut}, 17'h0);
  endtask

  task automatic writeStrobe(logic [23:0] cur);
    wrN = 1'b0;
    tick();
    check("R9", {flashOeN, flashWeN, adOe}, 3'b100);
    wrN = 1'b1;
    tick();
  endtask

  task automatic endBurst();
    csN = 1'b1;
    tick();
    check("R7", flashCeN, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] starts [8];
    starts = '{16'h0000, 16'h0001, 16'h7FFF, 16'h1234,
               16'hFFF0, 16'hFFFE, 16'hFFFF, 16'hABCD};
    tick(); tick();
    rst = 1'b0;
    tick();
    check("R1", flashAddr, 24'h0);

    for (int s = 0; s < 8; s++) begin
      for (int n = 0; n <= 20; n++) begin
        for (int mode = 0; mode < 3; mode++) begin
          logic [7:0] hi;
          logic [15:0] lo;
          hi = 8'(s * 37 + n + mode);
          startBurst(starts[s], hi);
          for (int k = 0; k < n; k++) begin
            lo = starts[s] + 16'(k);
            if (mode == 0 || (mode == 2 && k[0])) readStrobe({hi, lo}, lo ^ 16'h5A5A);
            else writeStrobe({hi, lo});
          end
          lo = starts[s] + 16'(n);
          // R3 R4 R5: start plus strobe count, modulo 2^16, upper byte held
          check(mode == 1 ? "R4" : "R3", flashAddr, {hi, lo});
          check("R5", flashAddr[23:16], hi);
          check("R10", flashAddr, {hi, lo});
          endBurst();
          // R6: strobes with select high do nothing
          rdN = 1'b0; tick(); rdN = 1'b1; tick();
          wrN = 1'b0; tick(); wrN = 1'b1; tick();
          check("R6", flashAddr, {hi, lo});
          check("R8", adOe, 1'b0);
        end
      end
    end

    // R5 explicit wrap
    startBurst(16'hFFFF, 8'h3C);
    readStrobe(24'h3CFFFF, 16'h0F0F);
    check("R5", flashAddr, 24'h3C0000);
    endBurst();

    // R1 reset mid-burst
    startBurst(16'h4444, 8'h55);
    rst = 1'b1; tick(); rst = 1'b0; csN = 1'b1; tick();
    check("R1", flashAddr, 24'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule